// File: doc/BRIEF.md
# HDLC Transmit Framer with Idle Character

This block turns bytes from a small transmit queue into a bit stream on one time slot of a frame-synchronized serial highway. In HDLC mode it wraps each frame in 0x7E flags, inserts a zero after five consecutive ones in the frame body and CRC, and appends a 16-bit frame check sequence. In transparent mode it sends the queued bytes unchanged. A programmable idle byte fills the line whenever nothing is queued.

The host writes a byte together with a close marker that flags the last byte of a frame. If the queue runs dry inside a frame before a byte with the close marker has been sent, the framer sends an abort instead of finishing the frame. A level output reports an empty queue. Another level output reports that transmission is finished. A one-cycle pulse reports an abort. The transmitter starts only at a frame-sync instant, so the first byte is never cut off by an enable that arrives at the wrong moment.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `txBit` is 1, `txEmpty` is 1 and `txAbort` is 0. In HDLC mode (`transparentMode`=0) `txDone` is 0.
- R2: Once `txEnable` is high, the framer emits nothing but 1 until it sees a cycle with `frameSync`=1 and `slotEn`=1. From that cycle on it emits one bit on every cycle with `slotEn`=1, and `frameSync` no longer matters.
- R3: Bytes go out least significant bit first. `txBit` is registered: each bit appears the cycle after the `slotEn` edge that sends it. When the queue is empty at a byte boundary, the byte `idleChar` is sent.
- R4: In HDLC mode a frame's first data byte is preceded by an opening flag 0x7E. The flag is left out when the previous byte on the line was a flag, that is a closing flag or an idle byte equal to 0x7E.
- R5: In HDLC mode a 0 is inserted after every five consecutive 1s in data and CRC bytes, and this also applies across byte boundaries. No insertion is made in flag, idle or abort bytes.
- R6: After the byte written with `wrLast`=1, the framer sends the FCS. The FCS is the CRC-16 with polynomial x^16+x^12+x^5+1, processed least significant bit first, preset to 0xFFFF and complemented. It is sent low byte first, followed by a closing flag 0x7E.
- R7: If the queue is empty at a data byte boundary and no close marker has been seen, the framer sends eight 1s unstuffed. In the same edge that puts the first of those 1s on `txBit`, `txAbort` pulses for one cycle.
- R8: In transparent mode bytes are sent unchanged, with no flags, no insertion, no CRC and no abort. In that mode `txDone` equals `txEmpty`, even while the transmitter is disabled.
- R9: `txEmpty` is 1 exactly when the queue (depth `DEPTH`, default 4) holds nothing. A write made while the queue is full is dropped.
- R10: In HDLC mode `txDone` rises in the cycle the last bit of a closing flag appears on `txBit`. It falls after the next accepted write.
- R11: Dropping `txEnable` forces `txBit` to 1 at the next edge. Queued bytes are kept, and the next start begins a new frame with an opening flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Transmitter on |
| transparentMode | input | 1 | 1 = raw bytes, 0 = HDLC framing |
| idleChar | input | 8 | Byte sent when the queue is empty |
| frameSync | input | 1 | Slot boundary marker used to start |
| slotEn | input | 1 | One bit is sent in this cycle |
| wrEn | input | 1 | Write a byte into the queue |
| wrData | input | 8 | Byte to queue |
| wrLast | input | 1 | Close marker: byte ends its frame |
| txBit | output | 1 | Serial output bit |
| txEmpty | output | 1 | Queue is empty |
| txDone | output | 1 | Transmission finished |
| txAbort | output | 1 | One-cycle abort pulse |

## Verification
The bench enables the transmitter away from a sync instant. A design that starts early would shift out a partial idle byte instead of holding 1. It sends payloads of 0xFF and 0x7E, where a framer without cross-byte zero insertion, or one that stuffs idle and flag bytes, would emit a false flag or a skewed bit count. It also sends back-to-back frames with a 0x7E idle byte, where a framer that always prepends a flag would send one flag too many. It starves the queue mid-frame, where a framer that pads with idle or closes the frame would miss the eight ones and the abort pulse. Further cases are writes to a full queue, which must be dropped, a disable in the middle of a frame, and transparent mode with an empty queue while disabled, where `txDone` must already be high.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] FLAG_BYTE = 8'h7E;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    UNIT_OFF, UNIT_IDLE, UNIT_OPEN, UNIT_DATA,
    UNIT_CRCLO, UNIT_CRCHI, UNIT_CLOSE, UNIT_ABORT
  } unit_e;

  typedef enum logic [2:0] {
    SRC_FIFO, SRC_IDLE, SRC_FLAG, SRC_ONES, SRC_CRCLO, SRC_CRCHI
  } src_e;

  typedef struct packed {
    logic clear;
    logic step;
    logic load;
    src_e src;
    logic stuffOn;
    logic crcOn;
    logic crcInit;
  } dp_ctl_t;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrLast,
  input  logic              popEn,
  output logic [DATA_W-1:0] headData,
  output logic              headLast,
  output logic              empty,
  output logic              wrAccept,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPop;

  assign empty = (count == '0);
  assign wrAccept = wrEn && (count != CNT_W'(DEPTH));
  assign doPop = popEn && !empty;
  assign {headLast, headData} = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrAccept) begin
        mem[wrPtr] <= {wrLast, wrData};
        wrPtr <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      case ({wrAccept, doPop})
        2'b10: count <= count + 1'b1;
        2'b01: count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           ctl,
  input  logic [BYTE_W-1:0] fifoByte,
  input  logic [BYTE_W-1:0] idleChar,
  output logic              txBit,
  output logic              unitEnd,
  output logic              finalBit
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shReg, srcByte;
  logic [CNT_W-1:0] bitsLeft;
  logic [2:0] onesCnt, onesNext;
  logic stuffPend, stuffNext, stuffOnL, crcOnL;
  logic [15:0] crc, crcBase, crcNext;
  logic curStuff, curCrc, isStuffBit, outBit, fb;

  assign unitEnd = (bitsLeft == '0) && !stuffPend;
  assign finalBit = (bitsLeft == CNT_W'(1)) && !stuffPend;

  always_comb begin
    case (ctl.src)
      SRC_FIFO:  srcByte = fifoByte;
      SRC_IDLE:  srcByte = idleChar;
      SRC_FLAG:  srcByte = FLAG_BYTE;
      SRC_CRCLO: srcByte = ~crc[7:0];
      SRC_CRCHI: srcByte = ~crc[15:8];
      default:   srcByte = '1;
    endcase
    curStuff = ctl.load ? ctl.stuffOn : stuffOnL;
    curCrc = ctl.load ? ctl.crcOn : crcOnL;
    crcBase = (ctl.load && ctl.crcInit) ? CRC_PRESET : crc;
    isStuffBit = !ctl.load && stuffPend;
    if (ctl.load) outBit = srcByte[0];
    else if (stuffPend) outBit = 1'b0;
    else outBit = shReg[0];
    fb = crcBase[0] ^ outBit;
    crcNext = (curCrc && !isStuffBit) ? ((crcBase >> 1) ^ (fb ? CRC_POLY_REV : 16'h0)) : crcBase;
    onesNext = (curStuff && !isStuffBit && outBit) ? onesCnt + 3'd1 : 3'd0;
    stuffNext = curStuff && !isStuffBit && outBit && (onesCnt == 3'd4);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBit <= 1'b1;
      shReg <= '1;
      bitsLeft <= '0;
      onesCnt <= '0;
      stuffPend <= 1'b0;
      stuffOnL <= 1'b0;
      crcOnL <= 1'b0;
      crc <= CRC_PRESET;
    end else if (ctl.clear) begin
      txBit <= 1'b1;
      bitsLeft <= '0;
      onesCnt <= '0;
      stuffPend <= 1'b0;
      stuffOnL <= 1'b0;
      crcOnL <= 1'b0;
    end else if (ctl.step) begin
      txBit <= outBit;
      crc <= crcNext;
      onesCnt <= onesNext;
      stuffPend <= stuffNext;
      if (ctl.load) begin
        shReg <= srcByte >> 1;
        bitsLeft <= CNT_W'(BYTE_W - 1);
        stuffOnL <= ctl.stuffOn;
        crcOnL <= ctl.crcOn;
      end else if (!stuffPend) begin
        shReg <= shReg >> 1;
        bitsLeft <= bitsLeft - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              transparentMode,
  input  logic [BYTE_W-1:0] idleChar,
  input  logic              frameSync,
  input  logic              slotEn,
  input  logic              fifoEmpty,
  input  logic              headLast,
  input  logic              wrAccept,
  input  logic              unitEnd,
  input  logic              finalBit,
  output dp_ctl_t           ctl,
  output logic              popEn,
  output logic              txActive,
  output logic              txDone,
  output logic              txAbort
);
  unit_e unit, nextUnit;
  logic lastFlag, curLast, doneFlag, step, load, flagLike;

  assign txActive = (unit != UNIT_OFF);
  assign step = txEnable && slotEn && (txActive || frameSync);
  assign load = step && unitEnd;

  always_comb begin
    if (transparentMode) begin
      nextUnit = fifoEmpty ? UNIT_IDLE : UNIT_DATA;
    end else begin
      case (unit)
        UNIT_DATA:  nextUnit = curLast ? UNIT_CRCLO : (fifoEmpty ? UNIT_ABORT : UNIT_DATA);
        UNIT_CRCLO: nextUnit = UNIT_CRCHI;
        UNIT_CRCHI: nextUnit = UNIT_CLOSE;
        UNIT_OPEN:  nextUnit = fifoEmpty ? UNIT_IDLE : UNIT_DATA;
        default:    nextUnit = fifoEmpty ? UNIT_IDLE : (lastFlag ? UNIT_DATA : UNIT_OPEN);
      endcase
    end
    ctl.clear = !txEnable;
    ctl.step = step;
    ctl.load = load;
    case (nextUnit)
      UNIT_DATA:  ctl.src = SRC_FIFO;
      UNIT_OPEN,
      UNIT_CLOSE: ctl.src = SRC_FLAG;
      UNIT_CRCLO: ctl.src = SRC_CRCLO;
      UNIT_CRCHI: ctl.src = SRC_CRCHI;
      UNIT_ABORT: ctl.src = SRC_ONES;
      default:    ctl.src = SRC_IDLE;
    endcase
    ctl.stuffOn = !transparentMode &&
                  (nextUnit == UNIT_DATA || nextUnit == UNIT_CRCLO || nextUnit == UNIT_CRCHI);
    ctl.crcOn = !transparentMode && (nextUnit == UNIT_DATA);
    ctl.crcInit = (nextUnit == UNIT_DATA) && (unit != UNIT_DATA);
    flagLike = (ctl.src == SRC_FLAG) || (ctl.src == SRC_IDLE && idleChar == FLAG_BYTE);
    popEn = load && (nextUnit == UNIT_DATA);
  end

  assign txDone = transparentMode ? fifoEmpty : doneFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      unit <= UNIT_OFF;
      lastFlag <= 1'b0;
      curLast <= 1'b0;
      doneFlag <= 1'b0;
      txAbort <= 1'b0;
    end else begin
      txAbort <= load && (nextUnit == UNIT_ABORT);
      if (!txEnable) begin
        unit <= UNIT_OFF;
        lastFlag <= 1'b0;
      end else if (load) begin
        unit <= nextUnit;
        lastFlag <= flagLike;
        if (popEn) curLast <= headLast;
      end
      if (step && !load && finalBit && unit == UNIT_CLOSE) doneFlag <= 1'b1;
      else if (wrAccept) doneFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txEnable,
  input  logic              transparentMode,
  input  logic [BYTE_W-1:0] idleChar,
  input  logic              frameSync,
  input  logic              slotEn,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              wrLast,
  output logic              txBit,
  output logic              txEmpty,
  output logic              txDone,
  output logic              txAbort
);
  dp_ctl_t ctl;
  logic popEn, headLast, wrAccept, unitEnd, finalBit, txActive;
  logic [BYTE_W-1:0] headData;
  logic [CNT_W-1:0] fifoCount;

  hdlc_tx_fifo #(.DATA_W(BYTE_W), .DEPTH(DEPTH)) fifo (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .wrLast(wrLast),
    .popEn(popEn), .headData(headData), .headLast(headLast), .empty(txEmpty),
    .wrAccept(wrAccept), .count(fifoCount)
  );

  hdlc_tx_ctrl ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .transparentMode(transparentMode),
    .idleChar(idleChar), .frameSync(frameSync), .slotEn(slotEn), .fifoEmpty(txEmpty),
    .headLast(headLast), .wrAccept(wrAccept), .unitEnd(unitEnd), .finalBit(finalBit),
    .ctl(ctl), .popEn(popEn), .txActive(txActive), .txDone(txDone), .txAbort(txAbort)
  );

  hdlc_tx_datapath dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .fifoByte(headData), .idleChar(idleChar),
    .txBit(txBit), .unitEnd(unitEnd), .finalBit(finalBit)
  );
endmodule

// File: rtl/hdlc_tx_framer_chk.sv
module hdlc_tx_framer_chk #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             txEnable,
  input logic             transparentMode,
  input logic             frameSync,
  input logic             slotEn,
  input logic             txBit,
  input logic             txAbort,
  input logic             txActive,
  input logic [CNT_W-1:0] fifoCount
);
  // R11
  disabled_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> txBit);

  // R2
  sync_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txActive) |-> ($past(frameSync) && $past(slotEn)));

  // R7
  abort_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |=> !txAbort);

  // R7
  abort_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    txAbort |-> txBit);

  // R8
  raw_no_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (transparentMode && $past(transparentMode)) |-> !txAbort);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));
endmodule

bind hdlc_tx_framer hdlc_tx_framer_chk #(.DEPTH(DEPTH)) chk (
  .clk(clk), .rstN(rstN), .txEnable(txEnable), .transparentMode(transparentMode),
  .frameSync(frameSync), .slotEn(slotEn), .txBit(txBit), .txAbort(txAbort),
  .txActive(txActive), .fifoCount(fifoCount)
);

// File: tb/hdlc_tx_framer_test.sv
module hdlc_tx_framer_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int U_OFF = 0, U_IDLE = 1, U_OPEN = 2, U_DATA = 3;
  localparam int U_CLO = 4, U_CHI = 5, U_CLOSE = 6, U_ABORT = 7;

  logic clk = 0, rstN = 0, txEnable = 0, transparentMode = 0;
  logic [7:0] idleChar = 8'hFF, wrData = 0;
  logic frameSync = 0, slotEn = 0, wrEn = 0, wrLast = 0;
  logic txBit, txEmpty, txDone, txAbort;

  int compared = 0, mismatched = 0, cyc = 0;
  string phase = "R1";
  bit seenAbort = 0;

  // reference model state
  int mUnit = U_OFF, mOnes = 0;
  bit bitQ[$];
  logic [8:0] fq[$];
  bit mLastFlag = 0, mCurLast = 0, mDone = 0, mAbort = 0, mBit = 1;
  logic [15:0] mCrc = 16'hFFFF;

  hdlc_tx_framer #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .transparentMode(transparentMode),
    .idleChar(idleChar), .frameSync(frameSync), .slotEn(slotEn), .wrEn(wrEn),
    .wrData(wrData), .wrLast(wrLast), .txBit(txBit), .txEmpty(txEmpty),
    .txDone(txDone), .txAbort(txAbort)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] crcByte(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[0] ^ b[i]) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  task automatic genBits(input logic [7:0] b, input bit stuff);
    for (int i = 0; i < 8; i++) begin
      bitQ.push_back(b[i]);
      if (stuff) begin
        if (b[i]) mOnes++; else mOnes = 0;
        if (mOnes == 5) begin bitQ.push_back(1'b0); mOnes = 0; end
      end else mOnes = 0;
    end
  endtask

  task automatic chooseUnit();
    int nu;
    logic [7:0] b;
    logic [8:0] e;
    bit stuffed = 0;
    if (transparentMode) nu = (fq.size() != 0) ? U_DATA : U_IDLE;
    else begin
      case (mUnit)
        U_DATA:  nu = mCurLast ? U_CLO : ((fq.size() != 0) ? U_DATA : U_ABORT);
        U_CLO:   nu = U_CHI;
        U_CHI:   nu = U_CLOSE;
        U_OPEN:  nu = (fq.size() != 0) ? U_DATA : U_IDLE;
        default: nu = (fq.size() == 0) ? U_IDLE : (mLastFlag ? U_DATA : U_OPEN);
      endcase
    end
    case (nu)
      U_IDLE: b = idleChar;
      U_OPEN, U_CLOSE: b = 8'h7E;
      U_ABORT: begin b = 8'hFF; mAbort = 1; end
      U_DATA: begin
        e = fq.pop_front();
        mCurLast = e[8];
        b = e[7:0];
        if (!transparentMode) begin
          if (mUnit != U_DATA) mCrc = 16'hFFFF;
          mCrc = crcByte(mCrc, b);
          stuffed = 1;
        end
      end
      U_CLO: begin b = ~mCrc[7:0]; stuffed = 1; end
      default: begin b = ~mCrc[15:8]; stuffed = 1; end
    endcase
    mLastFlag = (nu == U_OPEN) || (nu == U_CLOSE) || (nu == U_IDLE && idleChar == 8'h7E);
    mUnit = nu;
    genBits(b, stuffed);
  endtask

  always @(posedge clk) begin
    bit acc, stepNow, setDone;
    if (!rstN) begin
      mUnit = U_OFF; bitQ.delete(); fq.delete(); mOnes = 0; mLastFlag = 0;
      mCurLast = 0; mDone = 0; mAbort = 0; mBit = 1;
    end else begin
      acc = wrEn && (fq.size() < DEPTH);
      stepNow = txEnable && slotEn && (mUnit != U_OFF || frameSync);
      mAbort = 0;
      setDone = 0;
      if (!txEnable) begin
        mUnit = U_OFF; bitQ.delete(); mOnes = 0; mLastFlag = 0; mBit = 1;
      end else if (stepNow) begin
        if (bitQ.size() == 0) chooseUnit();
        mBit = bitQ.pop_front();
        if (mUnit == U_CLOSE && bitQ.size() == 0) setDone = 1;
      end
      if (acc) fq.push_back({wrLast, wrData});
      if (setDone) mDone = 1;
      else if (acc) mDone = 0;
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN) begin
      check(phase, "txBit (R3/R5 stream)", 16'(txBit), 16'(mBit));
      check("R9", "txEmpty", 16'(txEmpty), 16'(fq.size() == 0));
      check("R10", "txDone", 16'(txDone), 16'(transparentMode ? (fq.size() == 0) : mDone));
      check("R7", "txAbort", 16'(txAbort), 16'(mAbort));
      if (txAbort) seenAbort = 1;
    end
  end

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc++;
    #1;
    slotEn = (cyc % 5) != 4;
    frameSync = (cyc % 32) == 0;
    if (cyc > 100000) begin
      mismatched++;
      $display("FAIL watchdog expired actual=%0d expected<=100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wrByte(input logic [7:0] b, input bit last);
    wrEn = 1; wrData = b; wrLast = last;
    @(posedge clk); #2;
    wrEn = 0; wrLast = 0;
  endtask

  task automatic waitOffSync();
    while ((cyc % 32) < 3 || (cyc % 32) > 20) waitCyc(1);
  endtask

  initial begin
    waitCyc(4);
    rstN = 1;
    waitCyc(1);
    // R1: reset state
    check("R1", "txBit reset", 16'(txBit), 16'd1);
    check("R1", "txEmpty reset", 16'(txEmpty), 16'd1);
    check("R1", "txAbort reset", 16'(txAbort), 16'd0);
    check("R1", "txDone reset", 16'(txDone), 16'd0);

    // R2: enable away from sync, line must stay marking
    phase = "R2";
    idleChar = 8'h55;
    waitOffSync();
    txEnable = 1;
    waitCyc(8);
    check("R2", "txBit before sync", 16'(txBit), 16'd1);
    waitCyc(60);

    // R3 R4 R5 R6 R10: one frame with stuffing-heavy payload, all-ones idle
    phase = "R5";
    idleChar = 8'hFF;
    waitCyc(20);
    wrByte(8'hFF, 0);
    wrByte(8'h7E, 0);
    wrByte(8'h3C, 1);
    waitCyc(200);
    check("R10", "txDone after frame", 16'(txDone), 16'd1);

    // R4: shared flags between back-to-back frames with idle 0x7E
    phase = "R4";
    idleChar = 8'h7E;
    waitCyc(30);
    wrByte(8'hA5, 0);
    wrByte(8'h0F, 1);
    wrByte(8'hF8, 0);
    wrByte(8'h1F, 1);
    waitCyc(250);

    // R6: single-byte frame CRC
    phase = "R6";
    idleChar = 8'hFF;
    wrByte(8'h00, 1);
    waitCyc(150);

    // R7: underrun mid-frame
    phase = "R7";
    wrByte(8'h12, 0);
    wrByte(8'h34, 0);
    waitCyc(150);
    check("R7", "abort pulse seen", 16'(seenAbort), 16'd1);
    wrByte(8'h56, 1);
    waitCyc(150);

    // R9: full queue drops writes
    phase = "R9";
    txEnable = 0;
    waitCyc(2);
    wrByte(8'h11, 0);
    wrByte(8'h22, 0);
    wrByte(8'h33, 0);
    wrByte(8'h44, 1);
    wrByte(8'h99, 0);
    wrByte(8'h98, 1);
    check("R9", "txEmpty when full", 16'(txEmpty), 16'd0);
    txEnable = 1;
    waitCyc(250);
    check("R9", "txEmpty drained", 16'(txEmpty), 16'd1);

    // R11: disable mid-frame, queue kept, restart
    phase = "R11";
    wrByte(8'hC3, 0);
    wrByte(8'hFF, 0);
    wrByte(8'h81, 1);
    waitCyc(40);
    txEnable = 0;
    waitCyc(1);
    check("R11", "txBit after disable", 16'(txBit), 16'd1);
    waitCyc(10);
    txEnable = 1;
    waitCyc(200);

    // R8: transparent mode
    phase = "R8";
    txEnable = 0;
    waitCyc(3);
    transparentMode = 1;
    waitCyc(1);
    check("R8", "txDone with empty queue while off", 16'(txDone), 16'd1);
    idleChar = 8'hC5;
    wrByte(8'hFF, 0);
    wrByte(8'h7E, 0);
    wrByte(8'hF0, 1);
    check("R8", "txDone with queued bytes", 16'(txDone), 16'd0);
    txEnable = 1;
    waitCyc(150);
    txEnable = 0;
    waitCyc(5);

    summary();
    $finish;
  end
endmodule